// File: doc/BRIEF.md
# Guarded Byte Serial Shift Unit

This block moves one byte at a time over a four-wire serial link. It can act as the link master or as a slave. A processor controls it through three byte-wide registers: control, status and data. As master, an accepted write to the data register starts a full-duplex exchange. The block generates the serial clock by dividing the system clock by four. As slave, it loads the byte to send and waits for an external clock, which it brings through a two-flop synchronizer.

Two protection rules keep software from corrupting an exchange. A data write that arrives during a shift is dropped and raises a collision flag. A data write that arrives while the completion flag is still set, before software has read the status register, is also dropped. Both flags are cleared in two steps: read the status register while a flag is set, then access the data register. A control bit chooses whether bytes go out and come in most-significant bit first or least-significant bit first.

Register map, selected by `bus_addr`:

| Address | Register | Contents |
|---------|----------|----------|
| 0 | control | bit0 enable, bit1 master, bit2 LSB-first |
| 1 | status | bit7 completion flag, bit6 collision flag, all other bits read 0 |
| 2 | data | reads the last received or accepted byte |
| 3 | unused | reads 0 |

Top module: `spi_guard_core`

## Requirements
- R1: With control bits enable=1 and master=1 and no exchange running, an accepted data write starts an exchange. `sck_o` stays low for the first two system clocks after the write edge and then runs eight periods of four clocks each, high on the third and fourth clock of every period. It returns low and stays low once the exchange ends.
- R2: In master mode, `sdo_o` holds each transmit bit while `sck_o` rises. `sdi_i` is sampled on each rising edge. After completion, a data register read returns the eight sampled bits.
- R3: The completion flag (status bit7) is set in the same clock edge on which the eighth falling edge of `sck_o` occurs.
- R4: In slave mode (enable=1, master=0), a data write produces no clock on `sck_o`. The exchange runs on eight rising edges of `sck_i`. `sdo_o` presents the next bit before each rise, and the completion flag is set after the eighth rise.
- R5: A data write that arrives while an exchange is running is dropped and sets the collision flag (status bit6). This holds in both modes.
- R6: A data write that arrives while the completion flag is set and the status register has not been read since is dropped. It does not set the collision flag and does not start an exchange.
- R7: Control bit2 at 0 shifts MSB first and at 1 shifts LSB first, for both transmit and receive.
- R8: A status read with either flag set, followed by a data register read or write, clears both flags. In the write case, the write is also accepted.
- R9: Reset leaves the data register unchanged. While the block is disabled, the data register works as a plain storage byte.
- R10: If an exchange completes on the same edge as a flag-clearing data access, the completion flag ends up set. The collision flag is cleared.
- R11: After reset, control and status read 0 and both `sck_o` and `sdo_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| bus_sel | input | 1 | register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | register select |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data, valid the cycle after a read strobe |
| sck_o | output | 1 | serial clock driven in master mode |
| sck_i | input | 1 | serial clock from an external master in slave mode |
| sdo_o | output | 1 | serial data out |
| sdi_i | input | 1 | serial data in |

## Verification
The sensitive coincidence is an exchange completing on the same edge as the data access that finishes the flag-clearing sequence. The clear removes the flags, and the completion sets the completion flag again. To provoke it, the bench first raises the collision flag with a write during an exchange. It then reads status to arm the clear, and uses its own cycle-accurate model to place a data read exactly on the completion edge. The result is judged through the read data, which must show the previous byte, and through the next status read, which must show the completion flag set and the collision flag cleared.

// File: rtl/spi_guard_pkg.sv
package spi_guard_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic lsb_first;
    logic master;
    logic enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/sg_master_clk.sv
module sg_master_clk #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sck,
  output logic samp,
  output logic launch
);
  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [PH_W-1:0] ph_q;
  logic            sck_q;

  always_ff @(posedge clk) begin
    if (rst || !run) ph_q <= '0;
    else if (ph_q == PH_W'(DIV - 1)) ph_q <= '0;
    else ph_q <= ph_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else sck_q <= run && (ph_q >= PH_W'(HALF - 1)) && (ph_q < PH_W'(DIV - 1));
  end

  assign samp   = run && (ph_q == PH_W'(HALF - 1));
  assign launch = run && (ph_q == PH_W'(DIV - 1));
  assign sck    = sck_q;

  // R1
  sck_high_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sck_q) |=> sck_q);
  // R1
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sck_q);
endmodule

// File: rtl/sg_slave_edge.sv
module sg_slave_edge #(
  parameter int SYNC_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_in,
  output logic rise,
  output logic fall
);
  logic [SYNC_W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else sync_q <= {sync_q[SYNC_W-2:0], sck_in};
  end

  assign rise = sync_q[SYNC_W-2] && !sync_q[SYNC_W-1];
  assign fall = !sync_q[SYNC_W-2] && sync_q[SYNC_W-1];
endmodule

// File: rtl/sg_shifter.sv
module sg_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          master,
  input  logic          lsb_first,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          sample,
  input  logic          launch,
  input  logic          sdi,
  output logic          sdo,
  output logic          fin,
  output logic [DW-1:0] rx
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] sh_q;
  logic [DW-1:0] shifted;
  logic [CW-1:0] cnt_q;
  logic          sdo_q;

  always_comb begin
    if (lsb_first) shifted = {sdi, sh_q[DW-1:1]};
    else           shifted = {sh_q[DW-2:0], sdi};
  end

  assign fin = master ? (launch && cnt_q == CW'(DW))
                      : (sample && cnt_q == CW'(DW - 1));
  assign rx  = master ? sh_q : shifted;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cnt_q <= '0;
      sdo_q <= 1'b0;
    end else if (load) begin
      sh_q  <= load_data;
      cnt_q <= '0;
      sdo_q <= lsb_first ? load_data[0] : load_data[DW-1];
    end else begin
      if (sample) begin
        sh_q  <= shifted;
        cnt_q <= fin ? '0 : cnt_q + 1'b1;
      end
      if (launch) begin
        if (fin) cnt_q <= '0;
        else sdo_q <= lsb_first ? sh_q[0] : sh_q[DW-1];
      end
    end
  end

  assign sdo = sdo_q;

  // R1
  bit_count_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DW));
endmodule

// File: rtl/spi_guard_core.sv
module spi_guard_core
  import spi_guard_pkg::*;
#(
  parameter int DW  = 8,
  parameter int DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              sck_o,
  input  logic              sck_i,
  output logic              sdo_o,
  input  logic              sdi_i
);
  ctrl_t         ctrl_q;
  logic          done_q, coll_q, arm_q, busy_q;
  logic [DW-1:0] dreg_q;
  logic [DW-1:0] rdata_q;

  logic wr_ctrl, wr_data, rd_data, rd_stat, data_acc;
  logic blocked, accept;
  logic slave_act, run;
  logic m_samp, m_launch, s_rise, s_fall;
  logic sh_sample, sh_launch, fin, slave_start;
  logic [DW-1:0] rx_byte;

  assign wr_ctrl  = bus_sel && bus_we && (bus_addr == REG_CTRL);
  assign wr_data  = bus_sel && bus_we && (bus_addr == REG_DATA);
  assign rd_data  = bus_sel && !bus_we && (bus_addr == REG_DATA);
  assign rd_stat  = bus_sel && !bus_we && (bus_addr == REG_STAT);
  assign data_acc = wr_data || rd_data;

  assign blocked   = done_q && !arm_q;
  assign accept    = wr_data && !busy_q && !blocked;
  assign slave_act = ctrl_q.enable && !ctrl_q.master;
  assign run       = busy_q && ctrl_q.enable && ctrl_q.master;

  sg_master_clk #(.DIV(DIV)) u_mclk (
    .clk(clk), .rst(rst), .run(run),
    .sck(sck_o), .samp(m_samp), .launch(m_launch)
  );

  sg_slave_edge #(.SYNC_W(3)) u_sedge (
    .clk(clk), .rst(rst), .sck_in(sck_i),
    .rise(s_rise), .fall(s_fall)
  );

  assign sh_sample   = ctrl_q.master ? m_samp : (slave_act && s_rise);
  assign sh_launch   = ctrl_q.master ? m_launch : (slave_act && busy_q && s_fall);
  assign slave_start = slave_act && s_rise && !busy_q;

  sg_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst),
    .master(ctrl_q.master), .lsb_first(ctrl_q.lsb_first),
    .load(accept), .load_data(bus_wdata),
    .sample(sh_sample), .launch(sh_launch), .sdi(sdi_i),
    .sdo(sdo_o), .fin(fin), .rx(rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      done_q <= 1'b0;
      coll_q <= 1'b0;
      arm_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (rd_stat && (done_q || coll_q)) arm_q <= 1'b1;
      if (data_acc && arm_q) begin
        done_q <= 1'b0;
        coll_q <= 1'b0;
        arm_q  <= 1'b0;
      end
      if (wr_data && busy_q) coll_q <= 1'b1;
      if (accept && ctrl_q.enable && ctrl_q.master) busy_q <= 1'b1;
      if (slave_start) busy_q <= 1'b1;
      if (fin) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  // data register deliberately keeps its value through reset
  always_ff @(posedge clk) begin
    if (fin) dreg_q <= rx_byte;
    else if (accept) dreg_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_sel && !bus_we) begin
      unique case (bus_addr)
        REG_CTRL: rdata_q <= {{(DW-CTRL_W){1'b0}}, ctrl_q};
        REG_STAT: rdata_q <= {done_q, coll_q, {(DW-2){1'b0}}};
        REG_DATA: rdata_q <= dreg_q;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;

  // R5
  collision_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_data && busy_q) |=> coll_q);
  // R3
  done_on_finish_chk: assert property (@(posedge clk) disable iff (rst)
    fin |=> done_q);
  // R6
  blocked_write_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_data && done_q && !arm_q && !busy_q && !slave_start) |=> !busy_q);
  // R8
  clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data && arm_q && !fin) |=> (!done_q && !coll_q));
  // R4
  slave_no_clock_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.master && !$past(ctrl_q.master)) |-> !sck_o);
  // R2
  sdo_steady_high_chk: assert property (@(posedge clk) disable iff (rst)
    (run && sck_o && $past(sck_o)) |-> $stable(sdo_o));
endmodule

// File: tb/spi_guard_core_test.sv
module spi_guard_core_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       sck_o, sdo_o;
  logic       sck_i = 1'b0;
  logic       sdi_i = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spi_guard_core uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_o(sck_o), .sck_i(sck_i), .sdo_o(sdo_o), .sdi_i(sdi_i)
  );

  // behavioural reference state
  logic       m_en = 0, m_mst = 0, m_lsb = 0;
  logic       m_done = 0, m_coll = 0, m_arm = 0, m_busy = 0;
  int         m_mcyc = 0, m_scnt = 0;
  logic [2:0] m_h = 0;
  logic [7:0] m_dreg, m_tx = 0, m_sbyte = 0, m_srx = 0, m_rexp = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic o_busy, o_done, o_arm, o_coll, fin;
    if (rst) begin
      m_en = 0; m_mst = 0; m_lsb = 0; m_done = 0; m_coll = 0;
      m_arm = 0; m_busy = 0; m_mcyc = 0; m_scnt = 0; m_h = 0;
    end else begin
      o_busy = m_busy; o_done = m_done; o_arm = m_arm; o_coll = m_coll;
      fin = 0;
      if (m_busy && m_mst && m_en) begin
        if (m_mcyc == 31) fin = 1;
        else m_mcyc++;
      end
      if (m_en && !m_mst && m_h[1] && !m_h[2]) begin
        if (!m_busy) begin m_busy = 1; m_scnt = 0; end
        m_scnt++;
        if (m_scnt == 8) fin = 1;
      end
      m_h = {m_h[1:0], sck_i};
      if (bus_sel) begin
        if (!bus_we) begin
          case (bus_addr)
            2'd0: m_rexp = {5'b0, m_lsb, m_mst, m_en};
            2'd1: m_rexp = {o_done, o_coll, 6'b0};
            2'd2: m_rexp = m_dreg;
            default: m_rexp = 8'h00;
          endcase
          if (bus_addr == 2'd1 && (o_done || o_coll)) m_arm = 1;
        end else if (bus_addr == 2'd0) begin
          {m_lsb, m_mst, m_en} = bus_wdata[2:0];
        end
        if (bus_addr == 2'd2 && o_arm) begin
          m_done = 0; m_coll = 0; m_arm = 0;
        end
        if (bus_we && bus_addr == 2'd2) begin
          if (o_busy) m_coll = 1;
          else if (!(o_done && !o_arm)) begin
            m_dreg = bus_wdata;
            m_tx = bus_wdata;
            if (m_en && m_mst) begin m_busy = 1; m_mcyc = 0; end
          end
        end
      end
      if (fin) begin
        m_done = 1;
        m_busy = 0;
        m_dreg = m_mst ? m_sbyte : m_srx;
      end
    end
  end

  // per-clock comparison and external slave behaviour in master mode
  always @(negedge clk) begin
    if (!rst) begin
      int j;
      logic exp_sck;
      j = m_mcyc / 4;
      exp_sck = m_busy && m_mst && m_en && (m_mcyc % 4 == 2 || m_mcyc % 4 == 3);
      chk(sck_o, exp_sck, "R1/R4 sck_o per clock");
      if (m_busy && m_mst && m_en) begin
        if (m_mcyc % 4 == 2)
          chk(sdo_o, m_tx[m_lsb ? j : 7 - j], "R2/R7 sdo at rising edge");
        sdi_i = m_sbyte[m_lsb ? j : 7 - j];
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    chk(bus_rdata, exp, tag);
    chk(bus_rdata, m_rexp, {tag, " (model)"});
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic slave_byte(input logic [7:0] tx, input logic [7:0] rx, input bit collide);
    m_srx = rx;
    for (int j = 0; j < 8; j++) begin
      chk(sdo_o, tx[7 - j], "R4 slave sdo before rise");
      sdi_i = rx[7 - j];
      sck_i = 1;
      repeat (4) @(negedge clk);
      if (collide && j == 2) wr(2'd2, 8'hFF);
      sck_i = 0;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(sck_o, 0, "R11 sck_o after reset");
    chk(sdo_o, 0, "R11 sdo_o after reset");
    rd(2'd0, 8'h00, "R11 control after reset");
    rd(2'd1, 8'h00, "R11 status after reset");

    // R9: storage while disabled, survives reset
    wr(2'd2, 8'hA5);
    rd(2'd2, 8'hA5, "R9 storage byte");
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    rd(2'd2, 8'hA5, "R9 data kept through reset");

    // R1 R2 R3 R6 R8: master MSB first
    wr(2'd0, 8'h03);
    m_sbyte = 8'h3C;
    wr(2'd2, 8'h96);
    wait_idle();
    wr(2'd2, 8'h11);
    repeat (3) @(negedge clk);
    rd(2'd1, 8'h80, "R3 R6 done set, no collision");
    rd(2'd2, 8'h3C, "R2 R6 received byte, blocked write dropped");
    rd(2'd1, 8'h00, "R8 flags cleared by data read");

    // R5 R10: collision, then clear coinciding with completion
    m_sbyte = 8'h5A;
    wr(2'd2, 8'h81);
    repeat (5) @(negedge clk);
    wr(2'd2, 8'h22);
    rd(2'd1, 8'h40, "R5 collision flag during shift");
    while (m_mcyc != 31) @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = 2'd2;
    @(negedge clk);
    bus_sel = 0;
    chk(bus_rdata, 8'h81, "R10 data read on completion edge");
    rd(2'd1, 8'h80, "R10 done kept, collision cleared");

    // R8 write path: armed write clears and is accepted
    m_sbyte = 8'hE7;
    wr(2'd2, 8'h33);
    rd(2'd1, 8'h00, "R8 write clears flags");
    wait_idle();
    rd(2'd1, 8'h80, "R8 accepted write ran an exchange");
    rd(2'd2, 8'hE7, "R2 second received byte");

    // R7: LSB first
    wr(2'd0, 8'h07);
    m_sbyte = 8'hC1;
    wr(2'd2, 8'h0E);
    wait_idle();
    rd(2'd1, 8'h80, "R7 done after lsb exchange");
    rd(2'd2, 8'hC1, "R7 lsb-first received byte");

    // R4: slave mode with mid-byte collision
    wr(2'd0, 8'h01);
    wr(2'd2, 8'hC3);
    repeat (10) @(negedge clk);
    rd(2'd1, 8'h00, "R4 slave write starts nothing");
    slave_byte(8'hC3, 8'h6B, 1'b1);
    rd(2'd1, 8'hC0, "R4 R5 slave done with collision");
    rd(2'd2, 8'h6B, "R4 slave received byte");
    rd(2'd1, 8'h00, "R8 slave flags cleared");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule